// File: doc/BRIEF.md
# Byte-Aligning Load/Store Memory Unit

This unit connects one load/store stage to a memory port that reads and writes whole 32-bit words by word address. Each request carries a byte address, an operand size of one, two or four bytes, a byte-order select, a sign-extension select and a policy select. The unit decides whether the operand starts on a multiple of its own size. When it does, the request becomes one word access.

When the operand is misaligned, the unit follows one of two policies. Under the splitting policy it issues two word accesses to consecutive word addresses. For a load it then gathers the operand bytes from both returned words. For a store it writes the operand bytes with a lane mask on each word. Under the strict policy the request is refused: no memory access takes place and a trap flag is raised instead.

Byte order is chosen per request. Loads narrower than a word are widened to 32 bits, either with zeros or by copying the operand's top bit.

Top module: `lsu_align_unit`

## Requirements
- R1: An access of n bytes (size code 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 treated as 4 bytes) at byte address A is aligned when A mod n = 0. An aligned access, under either policy, performs exactly one word access at word address A[31:2].
- R2: With strict policy (req_strict = 1), a misaligned request makes no memory access and leaves memory unchanged. In the cycle after acceptance, trap and done are both 1 for exactly one cycle, and busy stays 0.
- R3: With split policy (req_strict = 0), a misaligned request performs exactly two word accesses: the first at A[31:2] and the second at A[31:2] + 1.
- R4: With req_big_endian = 0, operand byte i (i = 0 being the least significant) lives at byte address A + i.
- R5: With req_big_endian = 1, operand byte i lives at byte address A + n - 1 - i, so the most significant byte is at A.
- R6: A load of fewer than 4 bytes returns, on rdata, the operand zero-extended when req_signed = 0, or extended with its top bit when req_signed = 1.
- R7: On each word access, mem_be bit j (memory data bits 8j+7:8j, which hold byte offset j of that word) is 1 exactly when that byte belongs to the operand. A store changes only those bytes, and store data bits above the operand size have no effect.
- R8: busy is 1 from the cycle after a request is accepted until the final word handshake. done is then 1 for one cycle with busy at 0, and rdata holds the load result while done is 1.
- R9: mem_req stays 1, with mem_addr and mem_we unchanged, until mem_ack is seen. A word access completes on a cycle where both mem_req and mem_ack are 1.
- R10: trap stays 0 for every request that is carried out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; accepted when busy is 0 |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| req_signed | input | 1 | Sign-extend narrow loads |
| req_big_endian | input | 1 | Most significant byte at the lowest address |
| req_strict | input | 1 | Trap on misalignment instead of splitting |
| req_wdata | input | 32 | Store operand, right-justified |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| trap | output | 1 | Misalignment trap, pulses together with done |
| rdata | output | 32 | Extended load result |
| mem_req | output | 1 | Word access request |
| mem_we | output | 1 | Word access is a write |
| mem_addr | output | 30 | Word address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Write data, placed in lanes |
| mem_ack | input | 1 | Access accepted; read data valid |
| mem_rdata | input | 32 | Read word |

## Verification
The bench builds the unit with its default parameters: 32-bit byte addresses over 4-byte words. With these values every start offset (0 to 3) meets every operand size, so each case is reached: within-word misalignment, word-crossing misalignment, and the aligned path.

The memory model folds addresses into a 256-byte window. Random addresses therefore hit the same bytes repeatedly, and store-then-load sequences check each other. The window's wrap at the top word also exercises the split path at a word-address carry.

Random stalls on the acknowledge probe the hold behaviour of the word request.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } acc_state_e;

endpackage

// File: rtl/lsu_align_check.sv
module lsu_align_check #(
  parameter int OFF_W  = 2,
  parameter int SIZE_W = 2
) (
  input  logic [OFF_W-1:0]  off,
  input  logic [SIZE_W-1:0] size,
  output logic [OFF_W:0]    nbytes,
  output logic              misaligned
);

  logic [OFF_W-1:0] mask;

  always_comb begin
    if (int'(size) >= OFF_W) nbytes = (OFF_W+1)'(1) << OFF_W;
    else                     nbytes = (OFF_W+1)'(1) << size;
    mask       = nbytes[OFF_W-1:0] - OFF_W'(1);
    misaligned = |(off & mask);
  end

endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes #(
  parameter int WB    = 4,
  parameter int OFF_W = 2
) (
  input  logic [OFF_W-1:0] off,
  input  logic [OFF_W:0]   nbytes,
  input  logic             big,
  input  logic             second,
  input  logic [8*WB-1:0]  wdata,
  output logic [WB-1:0]    be,
  output logic [8*WB-1:0]  lane_data
);

  for (genvar j = 0; j < WB; j++) begin : g_lane
    logic       be_l;
    logic [7:0] d_l;

    always_comb begin
      int p;
      int k;
      int idx;
      p    = (second ? WB : 0) + j;
      k    = p - int'(off);
      idx  = 0;
      be_l = 1'b0;
      d_l  = 8'h00;
      if (k >= 0 && k < int'(nbytes)) begin
        idx  = big ? int'(nbytes) - 1 - k : k;
        be_l = 1'b1;
        d_l  = wdata[8*idx +: 8];
      end
    end

    assign be[j]            = be_l;
    assign lane_data[8*j +: 8] = d_l;
  end

endmodule

// File: rtl/lsu_load_merge.sv
module lsu_load_merge #(
  parameter int WB    = 4,
  parameter int OFF_W = 2
) (
  input  logic [OFF_W-1:0] off,
  input  logic [OFF_W:0]   nbytes,
  input  logic             big,
  input  logic             sign_ext,
  input  logic [8*WB-1:0]  w0,
  input  logic [8*WB-1:0]  w1,
  output logic [8*WB-1:0]  result
);

  logic [WB-1:0][7:0] raw;
  logic               top_bit;

  for (genvar i = 0; i < WB; i++) begin : g_byte
    logic [7:0] r_l;

    always_comb begin
      int k;
      int p;
      k   = big ? int'(nbytes) - 1 - i : i;
      p   = int'(off) + k;
      r_l = 8'h00;
      if (i < int'(nbytes)) begin
        if (p >= WB) r_l = w1[8*(p-WB) +: 8];
        else         r_l = w0[8*p +: 8];
      end
    end

    assign raw[i] = r_l;
  end

  always_comb begin
    top_bit = 1'b0;
    for (int i = 0; i < WB; i++) begin
      if (i == int'(nbytes) - 1) top_bit = raw[i][7];
    end
  end

  for (genvar i = 0; i < WB; i++) begin : g_ext
    assign result[8*i +: 8] = (i < int'(nbytes)) ? raw[i] : {8{sign_ext & top_bit}};
  end

endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
  import lsu_align_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4,
  localparam int DATA_W    = 8 * WORD_BYTES,
  localparam int OFF_W     = $clog2(WORD_BYTES),
  localparam int WADDR_W   = ADDR_W - OFF_W,
  localparam int SIZE_W    = $clog2(OFF_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [SIZE_W-1:0]  req_size,
  input  logic               req_signed,
  input  logic               req_big_endian,
  input  logic               req_strict,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               busy,
  output logic               done,
  output logic               trap,
  output logic [DATA_W-1:0]  rdata,
  output logic               mem_req,
  output logic               mem_we,
  output logic [WADDR_W-1:0] mem_addr,
  output logic [WORD_BYTES-1:0] mem_be,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic               mem_ack,
  input  logic [DATA_W-1:0]  mem_rdata
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  acc_state_e         state_q, state_d;
  logic [WADDR_W-1:0] waddr_q;
  logic [OFF_W-1:0]   off_q;
  logic [OFF_W:0]     nbytes_q;
  logic               big_q, sgn_q, we_q, split_q;
  logic [DATA_W-1:0]  wdata_q, w0_q, rdata_q;
  logic               done_q, trap_q;

  logic [OFF_W:0]     req_nbytes;
  logic               req_mis;
  logic               accept, trap_start, finish, cap_w0;
  logic               done_d, trap_d;
  logic [DATA_W-1:0]  merged, merge_w0;

  lsu_align_check #(.OFF_W(OFF_W), .SIZE_W(SIZE_W)) i_check (
    .off        (req_addr[OFF_W-1:0]),
    .size       (req_size),
    .nbytes     (req_nbytes),
    .misaligned (req_mis)
  );

  lsu_store_lanes #(.WB(WORD_BYTES), .OFF_W(OFF_W)) i_store (
    .off       (off_q),
    .nbytes    (nbytes_q),
    .big       (big_q),
    .second    (state_q == ST_SECOND),
    .wdata     (wdata_q),
    .be        (mem_be),
    .lane_data (mem_wdata)
  );

  assign merge_w0 = split_q ? w0_q : mem_rdata;

  lsu_load_merge #(.WB(WORD_BYTES), .OFF_W(OFF_W)) i_merge (
    .off      (off_q),
    .nbytes   (nbytes_q),
    .big      (big_q),
    .sign_ext (sgn_q),
    .w0       (merge_w0),
    .w1       (mem_rdata),
    .result   (merged)
  );

  // next-state logic
  always_comb begin
    accept     = req_valid && (state_q == ST_IDLE);
    trap_start = accept && req_strict && req_mis;
    finish     = mem_ack && (((state_q == ST_FIRST) && !split_q) || (state_q == ST_SECOND));
    cap_w0     = mem_ack && (state_q == ST_FIRST) && split_q;
    done_d     = finish || trap_start;
    trap_d     = trap_start;
    state_d    = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept && !trap_start) state_d = ST_FIRST;
      ST_FIRST:  if (mem_ack) state_d = split_q ? ST_SECOND : ST_IDLE;
      ST_SECOND: if (mem_ack) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      waddr_q  <= '0;
      off_q    <= '0;
      nbytes_q <= '0;
      big_q    <= 1'b0;
      sgn_q    <= 1'b0;
      we_q     <= 1'b0;
      split_q  <= 1'b0;
      wdata_q  <= '0;
      w0_q     <= '0;
      rdata_q  <= '0;
      done_q   <= 1'b0;
      trap_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      trap_q  <= trap_d;
      if (accept) begin
        waddr_q  <= req_addr[ADDR_W-1:OFF_W];
        off_q    <= req_addr[OFF_W-1:0];
        nbytes_q <= req_nbytes;
        big_q    <= req_big_endian;
        sgn_q    <= req_signed;
        we_q     <= req_write;
        split_q  <= req_mis;
        wdata_q  <= req_wdata;
      end
      if (cap_w0)             w0_q    <= mem_rdata;
      if (finish && !we_q)    rdata_q <= merged;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign mem_req  = busy;
  assign mem_we   = we_q;
  assign mem_addr = waddr_q + WADDR_W'(state_q == ST_SECOND);
  assign done     = done_q;
  assign trap     = trap_q;
  assign rdata    = rdata_q;

  // assertions
  p_trap_no_access_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (accept && req_strict && req_mis) |=> (trap && done && !mem_req));

  p_second_addr_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_SECOND && $past(state_q == ST_FIRST)) |-> (mem_addr == $past(mem_addr) + WADDR_W'(1)));

  p_first_lane_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_req && state_q == ST_FIRST) |-> (mem_be != '0));

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    done |-> !busy);

  p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (accept && !(req_strict && req_mis)) |=> busy);

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  p_trap_pulse_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    trap |=> !trap);

endmodule

// File: tb/test_lsu_align_unit.sv
module test_lsu_align_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_signed, req_big_endian, req_strict;
  logic [31:0] req_addr, req_wdata;
  logic [1:0]  req_size;
  logic        busy, done, trap;
  logic [31:0] rdata;
  logic        mem_req, mem_we;
  logic [29:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic        mem_ack;
  logic [31:0] mem_rdata;

  int tests = 0;
  int fails = 0;

  logic [7:0] mem_b   [256];
  logic [7:0] ref_mem [256];
  int         acc_cnt;
  logic [29:0] acc_addr [2];
  logic [3:0]  acc_be   [2];
  logic        pend_q;
  logic [29:0] pend_addr;

  always #10 clk = ~clk;

  lsu_align_unit i_lsu_align_unit (
    .clk, .rst_n, .req_valid, .req_write, .req_addr, .req_size, .req_signed,
    .req_big_endian, .req_strict, .req_wdata, .busy, .done, .trap, .rdata,
    .mem_req, .mem_we, .mem_addr, .mem_be, .mem_wdata, .mem_ack, .mem_rdata
  );

  // memory model with random acknowledge stalls
  always @(posedge clk) begin
    if (pend_q && mem_req) begin
      tests++;
      if (mem_addr != pend_addr) begin
        fails++;
        $display("FAIL R9: mem_addr moved while waiting, actual %h expected %h", mem_addr, pend_addr);
      end
    end
    pend_q    <= mem_req && !mem_ack;
    pend_addr <= mem_addr;
    if (mem_req && mem_ack) begin
      if (acc_cnt < 2) begin
        acc_addr[acc_cnt] = mem_addr;
        acc_be[acc_cnt]   = mem_be;
      end
      acc_cnt = acc_cnt + 1;
      if (mem_we) begin
        for (int j = 0; j < 4; j++)
          if (mem_be[j]) mem_b[{mem_addr[5:0], 2'(j)}] <= mem_wdata[8*j +: 8];
      end
    end
    if (mem_req && !mem_ack && ($urandom_range(3) != 0)) begin
      mem_ack <= 1'b1;
      for (int j = 0; j < 4; j++) mem_rdata[8*j +: 8] <= mem_b[{mem_addr[5:0], 2'(j)}];
    end else begin
      mem_ack <= 1'b0;
    end
  end

  function automatic int nb_of(input logic [1:0] sz);
    return (sz >= 2) ? 4 : (1 << sz);
  endfunction

  function automatic logic [31:0] exp_load(input logic [31:0] a, input int nb, input logic sg, input logic big);
    logic [31:0] v = '0;
    for (int i = 0; i < nb; i++) begin
      int k = big ? nb - 1 - i : i;
      v[8*i +: 8] = ref_mem[(a + 32'(k)) & 32'hFF];
    end
    if (sg && nb < 4 && v[8*nb-1]) for (int i = nb; i < 4; i++) v[8*i +: 8] = 8'hFF;
    return v;
  endfunction

  function automatic logic [3:0] exp_be(input logic [1:0] off, input int nb, input int w);
    logic [3:0] b = '0;
    for (int j = 0; j < 4; j++) begin
      int p = w * 4 + j;
      if (p >= int'(off) && p < int'(off) + nb) b[j] = 1'b1;
    end
    return b;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic wr, input logic [31:0] a, input logic [1:0] sz,
                        input logic sg, input logic big, input logic st, input logic [31:0] wd);
    int   nb  = nb_of(sz);
    logic mis = (int'(a[1:0]) % nb) != 0;
    int   wait_n = 0;
    logic [31:0] exp_r = exp_load(a, nb, sg, big);
    string dtag = (sg && nb < 4) ? "R6" : (big ? "R5" : "R4");
    @(negedge clk);
    acc_cnt = 0;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz;
    req_signed = sg; req_big_endian = big; req_strict = st; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (st && mis) begin
      chk("R2 trap", {29'd0, trap, done, busy}, 32'b110);
      @(negedge clk);
      chk("R2 no access", acc_cnt, 0);
      if (wr) begin
        for (int b = 0; b < 256; b++) if (mem_b[b] !== ref_mem[b]) begin
          chk("R2 memory", {24'd0, mem_b[b]}, {24'd0, ref_mem[b]}); break;
        end
      end
      return;
    end
    chk("R8 busy after accept", {31'd0, busy}, 32'd1);
    while (!done && wait_n < 200) begin
      @(negedge clk);
      wait_n++;
    end
    chk("R8 done with busy low", {30'd0, done, busy}, 32'b10);
    chk("R10 no trap", {31'd0, trap}, 32'd0);
    chk(mis ? "R3 access count" : "R1 access count", acc_cnt, mis ? 2 : 1);
    chk(mis ? "R3 first word" : "R1 word address", {2'b0, acc_addr[0]}, {4'd0, a[31:4], a[3:2]});
    if (mis) chk("R3 second word", {2'b0, acc_addr[1]}, {2'b0, a[31:2] + 30'd1});
    if (!wr) begin
      chk(dtag, rdata, exp_r);
    end else begin
      chk("R7 lanes word 0", {28'd0, acc_be[0]}, {28'd0, exp_be(a[1:0], nb, 0)});
      if (mis) chk("R7 lanes word 1", {28'd0, acc_be[1]}, {28'd0, exp_be(a[1:0], nb, 1)});
      for (int i = 0; i < nb; i++) begin
        int k = big ? nb - 1 - i : i;
        ref_mem[(a + 32'(k)) & 32'hFF] = wd[8*i +: 8];
      end
      @(negedge clk);
      begin
        int bad = -1;
        for (int b = 0; b < 256; b++) if (bad < 0 && mem_b[b] !== ref_mem[b]) bad = b;
        if (bad >= 0) chk(big ? "R5 R7 store" : "R4 R7 store", {24'd0, mem_b[bad]}, {24'd0, ref_mem[bad]});
        else chk("R7 store image", 32'd0, 32'd0);
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_size = '0;
    req_signed = 1'b0; req_big_endian = 1'b0; req_strict = 1'b0; req_wdata = '0;
    mem_ack = 1'b0; mem_rdata = '0; pend_q = 1'b0; pend_addr = '0; acc_cnt = 0;
    for (int b = 0; b < 256; b++) begin
      mem_b[b]   = 8'($urandom);
      ref_mem[b] = mem_b[b];
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 reset state", {28'd0, busy, done, trap, mem_req}, 32'd0);

    // directed corners
    run_op(1'b0, 32'h0000_0010, 2'd2, 1'b0, 1'b0, 1'b1, '0);            // aligned word, strict, LE
    run_op(1'b0, 32'h0000_0020, 2'd2, 1'b0, 1'b1, 1'b0, '0);            // aligned word, BE
    run_op(1'b1, 32'h0000_0043, 2'd1, 1'b0, 1'b0, 1'b0, 32'hFFFF_8081); // crossing half store LE
    run_op(1'b0, 32'h0000_0043, 2'd1, 1'b1, 1'b0, 1'b0, '0);            // read it back signed
    run_op(1'b1, 32'h0000_0051, 2'd1, 1'b0, 1'b1, 1'b0, 32'h0000_F00D); // in-word misaligned half BE
    run_op(1'b0, 32'h0000_0051, 2'd1, 1'b1, 1'b1, 1'b0, '0);
    run_op(1'b1, 32'h0000_0062, 2'd2, 1'b0, 1'b1, 1'b0, 32'hA1B2_C3D4); // split word store BE
    run_op(1'b0, 32'h0000_0062, 2'd3, 1'b0, 1'b0, 1'b0, '0);            // size code 3, LE read
    run_op(1'b1, 32'h0000_0071, 2'd2, 1'b0, 1'b0, 1'b1, 32'h1234_5678); // strict trap store
    run_op(1'b0, 32'h0000_0073, 2'd1, 1'b0, 1'b0, 1'b1, '0);            // strict trap load
    run_op(1'b1, 32'h0000_0085, 2'd0, 1'b0, 1'b0, 1'b1, 32'hFFFF_FF80); // byte store, strict ok
    run_op(1'b0, 32'h0000_0085, 2'd0, 1'b1, 1'b0, 1'b1, '0);            // signed byte
    run_op(1'b0, 32'h0000_0085, 2'd0, 1'b0, 1'b1, 1'b1, '0);            // unsigned byte
    run_op(1'b0, 32'h0000_00FF, 2'd2, 1'b0, 1'b0, 1'b0, '0);            // window wrap split

    for (int n = 0; n < 400; n++)
      run_op(1'($urandom), $urandom, 2'($urandom), 1'($urandom), 1'($urandom),
             ($urandom_range(3) == 0), $urandom);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule